// File: doc/BRIEF.md
# Triangular Down-Spread Ratio Profile Generator

This block produces the frequency-modulation profile for a spread-spectrum clock synthesizer. Each clock it updates a fixed-point divide-ratio word, which goes to the delta-sigma modulator of a fractional-N feedback divider. The word starts at the nominal ratio and falls by a programmable step on every clock until it reaches a floor set by the spread depth. It then climbs back by the same step until it reaches the nominal ratio again. The result is a symmetric triangle that only ever lowers the synthesized frequency.

The block is clocked by a clock that already exists in the loop, such as the reference or the divided feedback clock, so no separate modulation clock is needed. The modulation period is a count of that clock, and it is set by the ratio of depth to step. As an example, a 25 MHz reference, a nominal ratio of 60.0, a depth of 19201 LSB (about 4883 ppm) and a step of 47 LSB give a period of 818 clocks. That is close to 30 kHz. The depth, step and nominal ratio are static configuration and may only change while the enable is low.

Top module: `tri_spread_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next `ratio_out` equals `nominal` and `dir_down` is 1, whatever `en` is.
- R2: While `en` is low at a rising edge, the next `ratio_out` equals `nominal` as it was at that edge, and `dir_down` is 1.
- R3: While descending (`dir_down` = 1) and `ratio_out` is greater than floor + `step`, the next value is `ratio_out` − `step` and the direction is kept.
- R4: The floor is `nominal` − `depth`, or 0 when `depth` ≥ `nominal`. While descending with `ratio_out` ≤ floor + `step`, the next value is exactly the floor and `dir_down` becomes 0.
- R5: While ascending (`dir_down` = 0) and `ratio_out` + `step` is less than `nominal`, the next value is `ratio_out` + `step` and the direction is kept.
- R6: While ascending with `ratio_out` + `step` ≥ `nominal`, the next value is exactly `nominal` and `dir_down` becomes 1.
- R7: While enabled with a static configuration, `ratio_out` never exceeds `nominal` and never falls below the floor, with no overshoot even when `depth` is not a multiple of `step`.
- R8: With effective depth D = min(`depth`, `nominal`) and step S > 0, the profile repeats every 2·max(1, ⌈D/S⌉) clocks. The falling and rising halves have equal length, and `dir_down` toggles exactly twice per period.
- R9: With `depth` = 0, `ratio_out` stays at `nominal` while `dir_down` toggles on every clock.
- R10: Dropping `en` mid-ramp returns `ratio_out` to `nominal`, with `dir_down` = 1, on the next clock. Raising it again starts a fresh period whose first value is `nominal` − `step`.
- R11: All ratio words are unsigned fixed point, with `INT_W` integer bits above 16 fractional bits (bit 16 weighs 1.0). `dir_down` = 1 means descending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Existing loop clock (reference or divided feedback) |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enables modulation; low holds the nominal ratio |
| nominal | input | INT_W+16 | Nominal (centre, highest) divide ratio |
| depth | input | INT_W+16 | Spread depth, in ratio LSBs below nominal |
| step | input | INT_W+16 | Ratio change applied per clock |
| ratio_out | output | INT_W+16 | Current divide-ratio word to the modulator |
| dir_down | output | 1 | 1 while descending, 0 while ascending |

## Verification
The clamp to a limit and the direction reversal happen in the same clock. Both are decided by a single look-ahead comparison, so the corner that matters is a depth that is not a multiple of the step, where the last move is a partial one. A sweep over several small nominal, depth and step combinations, including depths of zero, depths above the nominal and steps larger than the depth, makes those final steps land on every residue. Each cycle is judged against an arithmetic model of the triangle. The bench also drops the enable and asserts reset part-way down a ramp, so that a return to idle coincides with an ordinary step, and checks that idle wins.

// File: rtl/tsg_pkg.sv
// Package: shared constants and types for the triangular spread generator.
// Assumes ratio words are unsigned fixed point with a 16-bit fraction.
package tsg_pkg;
    localparam int FRAC_W = 16;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } ramp_dir_e;
endpackage

// File: rtl/tsg_floor_calc.sv
// Module: derives the lowest ratio of the sweep from nominal and depth.
// Assumes both inputs are unsigned; saturates at zero when depth >= nominal.
module tsg_floor_calc #(
    parameter int W = 22
) (
    input  logic [W-1:0] nominal,
    input  logic [W-1:0] depth,
    output logic [W-1:0] floor_val
);
    // Saturating subtraction of the spread depth from the nominal ratio.
    always_comb begin
        if (depth >= nominal) floor_val = '0;
        else                  floor_val = nominal - depth;
    end
endmodule

// File: rtl/tsg_step_unit.sv
// Module: look-ahead arithmetic for one clock of the ramp.
// Assumes floor_val <= nominal; limit tests use one guard bit so no wrap.
module tsg_step_unit #(
    parameter int W = 22
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] step,
    input  logic [W-1:0] floor_val,
    input  logic [W-1:0] nominal,
    output logic [W-1:0] dec_val,
    output logic [W-1:0] inc_val,
    output logic         at_floor,
    output logic         at_top
);
    localparam int WG = W + 1;

    logic [WG-1:0] cur_g;
    logic [WG-1:0] floor_plus;
    logic [WG-1:0] cur_plus;

    // Candidate values for a plain step in either direction.
    always_comb begin
        dec_val = cur - step;
        inc_val = cur + step;
    end

    // Guarded sums that decide whether the next step reaches a limit.
    always_comb begin
        cur_g      = {1'b0, cur};
        floor_plus = {1'b0, floor_val} + {1'b0, step};
        cur_plus   = {1'b0, cur} + {1'b0, step};
        at_floor   = (cur_g <= floor_plus);
        at_top     = (cur_plus >= {1'b0, nominal});
    end
endmodule

// File: rtl/tsg_ramp_reg.sv
// Module: ratio register and direction state of the triangle.
// Assumes the step unit flags describe the current register value.
module tsg_ramp_reg
    import tsg_pkg::*;
#(
    parameter int W = 22
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] nominal,
    input  logic [W-1:0] floor_val,
    input  logic [W-1:0] dec_val,
    input  logic [W-1:0] inc_val,
    input  logic         at_floor,
    input  logic         at_top,
    output logic [W-1:0] ratio_q,
    output logic         dir_down
);
    ramp_dir_e dir_q;

    // Advance, clamp and reverse the ratio; idle or reset parks it at nominal.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ratio_q <= nominal;
            dir_q   <= DIR_DOWN;
        end else if (dir_q == DIR_DOWN) begin
            if (at_floor) begin
                ratio_q <= floor_val;
                dir_q   <= DIR_UP;
            end else begin
                ratio_q <= dec_val;
            end
        end else begin
            if (at_top) begin
                ratio_q <= nominal;
                dir_q   <= DIR_DOWN;
            end else begin
                ratio_q <= inc_val;
            end
        end
    end

    // Expose the direction as a plain flag.
    always_comb dir_down = (dir_q == DIR_DOWN);
endmodule

// File: rtl/tri_spread_gen.sv
// Module: top of the triangular down-spread ratio profile generator.
// Assumes nominal, depth and step only change while en is low.
module tri_spread_gen
    import tsg_pkg::*;
#(
    parameter int INT_W = 6,
    localparam int RATIO_W = INT_W + FRAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [RATIO_W-1:0] nominal,
    input  logic [RATIO_W-1:0] depth,
    input  logic [RATIO_W-1:0] step,
    output logic [RATIO_W-1:0] ratio_out,
    output logic               dir_down
);
    logic [RATIO_W-1:0] floor_val;
    logic [RATIO_W-1:0] dec_val;
    logic [RATIO_W-1:0] inc_val;
    logic               at_floor;
    logic               at_top;

    tsg_floor_calc #(.W(RATIO_W)) u_floor (
        .nominal   (nominal),
        .depth     (depth),
        .floor_val (floor_val)
    );

    tsg_step_unit #(.W(RATIO_W)) u_step (
        .cur       (ratio_out),
        .step      (step),
        .floor_val (floor_val),
        .nominal   (nominal),
        .dec_val   (dec_val),
        .inc_val   (inc_val),
        .at_floor  (at_floor),
        .at_top    (at_top)
    );

    tsg_ramp_reg #(.W(RATIO_W)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .nominal   (nominal),
        .floor_val (floor_val),
        .dec_val   (dec_val),
        .inc_val   (inc_val),
        .at_floor  (at_floor),
        .at_top    (at_top),
        .ratio_q   (ratio_out),
        .dir_down  (dir_down)
    );
endmodule

// File: rtl/tsg_checker.sv
// Module: temporal checks on the ratio profile, bound to the top.
// Assumes configuration is static while en is high.
module tsg_checker #(
    parameter int W = 22
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic [W-1:0] nominal,
    input logic [W-1:0] depth,
    input logic [W-1:0] step,
    input logic [W-1:0] ratio_out,
    input logic         dir_down
);
    function automatic logic [W-1:0] low_of(input logic [W-1:0] n, input logic [W-1:0] d);
        return (d >= n) ? '0 : n - d;
    endfunction

    // R2
    idle_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (ratio_out == $past(nominal)) && dir_down);

    // R3
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(en) && $past(dir_down) && dir_down
        |-> ratio_out == $past(ratio_out) - $past(step));

    // R4
    floor_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(en) && $past(dir_down) && !dir_down
        |-> ratio_out == low_of($past(nominal), $past(depth)));

    // R5
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(en) && !$past(dir_down) && !dir_down
        |-> ratio_out == $past(ratio_out) + $past(step));

    // R6
    top_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(en) && !$past(dir_down) && dir_down
        |-> ratio_out == $past(nominal));

    // R7
    ratio_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(en) && $stable(nominal) && $stable(depth)
        |-> (ratio_out <= nominal) && (ratio_out >= low_of(nominal, depth)));
endmodule

bind tri_spread_gen tsg_checker #(.W(RATIO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .nominal   (nominal),
    .depth     (depth),
    .step      (step),
    .ratio_out (ratio_out),
    .dir_down  (dir_down)
);

// File: tb/tri_spread_gen_test.sv
// Bench: sweeps small configurations against an arithmetic triangle model.
module tri_spread_gen_test;
    localparam int INT_W = 6;
    localparam int W = INT_W + 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst_n;
    logic         en;
    logic [W-1:0] nominal;
    logic [W-1:0] depth;
    logic [W-1:0] step;
    logic [W-1:0] ratio_out;
    logic         dir_down;

    int  total = 0;
    int  bad = 0;
    int  cyc = 0;
    bit  timed_out = 0;

    tri_spread_gen #(.INT_W(INT_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .nominal   (nominal),
        .depth     (depth),
        .step      (step),
        .ratio_out (ratio_out),
        .dir_down  (dir_down)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !timed_out) begin
            timed_out = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Run one configuration for a number of periods, checking every clock.
    task automatic run_cfg(input longint n, input longint d, input longint s, input int periods);
        longint dp, fl, half, p, exp_r;
        bit     exp_d, prev_d;
        int     toggles;
        string  tag;
        nominal = W'(n); depth = W'(d); step = W'(s); en = 1'b0;
        tick(); tick();
        chk(longint'(ratio_out) == n && dir_down, "R2 idle", longint'(ratio_out), n);
        dp = (d > n) ? n : d;
        fl = n - dp;
        half = (dp == 0) ? 1 : (dp + s - 1) / s;
        en = 1'b1;
        prev_d = 1'b1;
        toggles = 0;
        for (longint t = 1; t <= 2 * half * periods; t++) begin
            tick();
            p = t % (2 * half);
            if (p == 0)         begin exp_r = n;                  exp_d = 1'b1; tag = "R6"; end
            else if (p < half)  begin exp_r = n - p * s;          exp_d = 1'b1; tag = "R3"; end
            else if (p == half) begin exp_r = fl;                 exp_d = 1'b0; tag = "R4"; end
            else                begin exp_r = fl + (p - half) * s; exp_d = 1'b0; tag = "R5"; end
            if (dp == 0) tag = "R9";
            chk(longint'(ratio_out) == exp_r, tag, longint'(ratio_out), exp_r);
            chk(dir_down == exp_d, {tag, " dir"}, longint'(dir_down), longint'(exp_d));
            chk(longint'(ratio_out) <= n && longint'(ratio_out) >= fl, "R7 bounds",
                longint'(ratio_out), fl);
            if (dir_down != prev_d) toggles++;
            prev_d = dir_down;
            if (p == 0) begin
                chk(toggles == 2, "R8 toggles per period", toggles, 2);
                toggles = 0;
            end
        end
        en = 1'b0;
        tick();
        chk(longint'(ratio_out) == n && dir_down, "R2 after disable", longint'(ratio_out), n);
    endtask

    initial begin
        longint nlist[2] = '{200, 5};
        longint dlist[6] = '{0, 1, 6, 7, 13, 40};
        longint slist[5] = '{1, 2, 3, 7, 16};
        longint rn, rf;
        rst_n = 1'b0; en = 1'b1; nominal = W'(500); depth = W'(30); step = W'(4);
        tick();
        chk(longint'(ratio_out) == 500 && dir_down, "R1 reset", longint'(ratio_out), 500);
        tick();
        rst_n = 1'b1;
        tick();
        chk(longint'(ratio_out) == 496, "R3 first step after reset", longint'(ratio_out), 496);
        tick();
        rst_n = 1'b0;
        tick();
        chk(longint'(ratio_out) == 500 && dir_down, "R1 reset mid-ramp", longint'(ratio_out), 500);
        rst_n = 1'b1;

        foreach (nlist[i]) foreach (dlist[j]) foreach (slist[k])
            run_cfg(nlist[i], dlist[j], slist[k], 2);

        // R10: disable part-way down, then restart
        nominal = W'(1000); depth = W'(50); step = W'(7); en = 1'b0;
        tick(); tick();
        en = 1'b1;
        tick(); tick(); tick();
        chk(longint'(ratio_out) == 979, "R10 mid-ramp value", longint'(ratio_out), 979);
        en = 1'b0;
        tick();
        chk(longint'(ratio_out) == 1000 && dir_down, "R10 disable returns", longint'(ratio_out), 1000);
        en = 1'b1;
        tick();
        chk(longint'(ratio_out) == 993, "R10 fresh period", longint'(ratio_out), 993);

        // R11: realistic setting, ratio 60.0 with 19201 LSB depth and step 47
        rn = 60 * 65536;
        run_cfg(rn, 19201, 47, 1);
        rf = rn - 19201;
        en = 1'b1;
        for (int t = 0; t < 409; t++) tick();
        chk(longint'(ratio_out) == rf, "R11 floor word", longint'(ratio_out), rf);
        chk(longint'(ratio_out[W-1:16]) == 59, "R11 integer field", longint'(ratio_out[W-1:16]), 59);
        chk(dir_down == 1'b0, "R11 direction code", longint'(dir_down), 0);
        en = 1'b0;
        tick();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule